// File: doc/BRIEF.md
# UART Receive Character Queue

This block is the receive-side character queue of a 16550-style serial port. Each character that the serial shifter hands over is written with its parity-error, framing-error and break flags. The queue keeps up to sixteen of these entries and shows the oldest one to the register read path. It also produces the four status indications that the interrupt logic uses: data ready, trigger level reached, overrun and character timeout.

A write to the queue control register sets the trigger level and turns queued mode on or off. The same write can empty the receive queue. The transmit-clear bit belongs to another block and has no effect here.

The character-timeout indication catches data that is left waiting below the trigger level. The baud logic supplies a strobe once per character time. If a set number of these strobes pass with data queued, the level below the trigger, no new character, no read and an idle line, the indication is raised.

Top module: `urxq_top`

## Requirements
- R1: After reset, data_ready, trig_hit, overrun and char_timeout are all 0. Queued mode is off and the trigger selector is 00.
- R2: Characters leave in arrival order. While data_ready is 1, buf_data, buf_perr, buf_ferr and buf_brk show the oldest entry. A buf_rd pulse removes that entry at the next clock edge.
- R3: With queued mode on (control bit 0 = 1), the queue holds 16 entries. A push into a full queue is dropped, the 16 stored entries stay intact, and overrun goes to 1 on the next cycle.
- R4: Once overrun is set, it stays 1 until a stat_rd pulse. It then reads 0 from the following cycle.
- R5: Control bits 7:6 select the trigger level: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14. trig_hit is 1 exactly when the occupancy is at or above the selected level. It is updated one cycle after a push, a read or a control write.
- R6: A control write with bit 1 = 1 empties the receive queue, so data_ready is 0 on the next cycle. A control write with bit 1 = 0, including one with bit 2 = 1, leaves the stored characters and the head entry unchanged.
- R7: A buf_rd while the queue is empty has no effect. After it, one pushed character makes data_ready 1, and a single read then makes it 0 again.
- R8: A push with rx_brk = 1 is stored as data 0x00 with buf_brk = 1 and buf_ferr = 1. This holds whatever value rx_data has.
- R9: char_timeout goes to 1 on the 4th char_tick, counted while all of these hold: the queue is non-empty, the occupancy is below the trigger level, and there is no push, no read and no rx_busy. It does not go to 1 at or above the trigger level. A read clears it on the next cycle.
- R10: A push or a cycle with rx_busy = 1 restarts the count of char_tick strobes toward the timeout.
- R11: With queued mode off (control bit 0 = 0), the capacity is one character. A second push before a read is dropped and sets overrun.
- R12: data_ready is 1 exactly when the queue holds at least one character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_push | input | 1 | Character strobe from the receive shifter |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error flag of the character |
| rx_ferr | input | 1 | Framing error flag of the character |
| rx_brk | input | 1 | Character is a break condition |
| rx_busy | input | 1 | Receive line activity (a frame is in progress) |
| char_tick | input | 1 | One-cycle strobe once per character time |
| ctl_we | input | 1 | Write strobe of the queue control register |
| ctl_data | input | 8 | Control value: 7:6 trigger selector, 1 clear receive, 0 queued mode |
| buf_rd | input | 1 | Read of the receive buffer (pops the head) |
| stat_rd | input | 1 | Read of line status (clears overrun) |
| buf_data | output | 8 | Head character |
| buf_perr | output | 1 | Head parity error flag |
| buf_ferr | output | 1 | Head framing error flag |
| buf_brk | output | 1 | Head break flag |
| data_ready | output | 1 | Queue not empty |
| trig_hit | output | 1 | Occupancy at or above trigger level |
| overrun | output | 1 | A character was dropped |
| char_timeout | output | 1 | Character timeout indication |

## Verification
Each status output is a register. A push, read, clear, control write, status read or character strobe presented before a clock edge is visible right after that edge, so every expected value is due one cycle after its stimulus. The head entry outputs follow the read pointer combinationally, so they are due in that same cycle. The bench drives inputs on the falling edge, holds them through one rising edge, and then samples on the next falling edge. Every comparison therefore falls in the cycle where the new value is due. The timeout checks sample after the third and after the fourth strobe, so they catch a count that is off by one in either direction.

// File: rtl/urxq_pkg.sv
package urxq_pkg;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } urxq_ent_t;

  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   trig_level = 5'd1;
      2'b01:   trig_level = 5'd4;
      2'b10:   trig_level = 5'd8;
      default: trig_level = 5'd14;
    endcase
  endfunction

endpackage

// File: rtl/urxq_store.sv
module urxq_store
  import urxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  urxq_ent_t                    wr_ent,
  input  logic                         rd_en,
  input  logic                         clr,
  input  logic                         cap_one,
  output urxq_ent_t                    head,
  output logic                         full,
  output logic                         wr_ok,
  output logic                         rd_ok,
  output logic [$clog2(DEPTH+1)-1:0]   cnt_q,
  output logic [$clog2(DEPTH+1)-1:0]   cnt_d
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  urxq_ent_t      mem [DEPTH];
  logic [AW-1:0]  wp, rp;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    nxt = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = cap_one ? (cnt_q != '0) : (cnt_q == CW'(DEPTH));
  assign wr_ok = wr_en & ~full & ~clr;
  assign rd_ok = rd_en & (cnt_q != '0) & ~clr;
  assign head  = mem[rp];

  always_comb begin
    cnt_d = cnt_q;
    if (clr) cnt_d = '0;
    else if (wr_ok & ~rd_ok) cnt_d = cnt_q + 1'b1;
    else if (rd_ok & ~wr_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_ent;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wp <= nxt(wp);
      if (rd_ok) rp <= nxt(rp);
      cnt_q <= cnt_d;
    end
  end

  // R3: a push into a full queue leaves the occupancy unchanged
  p_drop_full_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !clr && !rd_en) |=> (cnt_q == $past(cnt_q)));
  // R7: a read of an empty queue cannot wrap the counter
  p_empty_read_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cnt_q == '0 && !wr_en && !clr) |=> (cnt_q == '0));
  // R6: clearing empties the queue
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/urxq_flags.sv
module urxq_flags
  import urxq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_d,
  input  logic [1:0]    sel_d,
  input  logic          drop,
  input  logic          stat_rd,
  output logic          drdy_q,
  output logic          trig_q,
  output logic          ovr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      drdy_q <= 1'b0;
      trig_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      drdy_q <= (cnt_d != '0);
      trig_q <= (cnt_d >= CW'(trig_level(sel_d)));
      if (drop) ovr_q <= 1'b1;
      else if (stat_rd) ovr_q <= 1'b0;
    end
  end

  // R4: overrun holds until the status read
  p_ovr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !stat_rd) |=> ovr_q);
  // R3: a dropped character always raises overrun
  p_ovr_set_r3: assert property (@(posedge clk) disable iff (rst)
    drop |=> ovr_q);

endmodule

// File: rtl/urxq_timeout.sv
module urxq_timeout #(
  parameter int CW       = 5,
  parameter int TO_CHARS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          busy,
  input  logic          push,
  input  logic          rd_ok,
  input  logic          clr,
  input  logic [CW-1:0] cnt_q,
  input  logic          trig_q,
  output logic          to_q
);
  localparam int TW = $clog2(TO_CHARS + 1);

  logic [TW-1:0] tcnt;
  logic          restart;

  assign restart = push | rd_ok | busy | clr | (cnt_q == '0) | trig_q;

  always_ff @(posedge clk) begin
    if (rst || restart) tcnt <= '0;
    else if (tick && tcnt != TW'(TO_CHARS)) tcnt <= tcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || rd_ok || clr) to_q <= 1'b0;
    else if (!restart && tick && tcnt == TW'(TO_CHARS - 1)) to_q <= 1'b1;
  end

  // R9: a read always removes the timeout indication
  p_read_clears_to_r9: assert property (@(posedge clk) disable iff (rst)
    rd_ok |=> !to_q);
  // R10: line activity keeps the timeout from rising
  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && !to_q) |=> !to_q);

endmodule

// File: rtl/urxq_top.sv
module urxq_top
  import urxq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int TO_CHARS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_push,
  input  logic [7:0] rx_data,
  input  logic       rx_perr,
  input  logic       rx_ferr,
  input  logic       rx_brk,
  input  logic       rx_busy,
  input  logic       char_tick,
  input  logic       ctl_we,
  input  logic [7:0] ctl_data,
  input  logic       buf_rd,
  input  logic       stat_rd,
  output logic [7:0] buf_data,
  output logic       buf_perr,
  output logic       buf_ferr,
  output logic       buf_brk,
  output logic       data_ready,
  output logic       trig_hit,
  output logic       overrun,
  output logic       char_timeout
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          en_q;
  logic [1:0]    sel_q, sel_d;
  logic          clr, full, wr_ok, rd_ok, drop;
  logic [CW-1:0] cnt_q, cnt_d;
  urxq_ent_t     in_ent, head;
  logic [3:0]    unused_ctl;

  assign unused_ctl = ctl_data[5:2];
  assign clr   = ctl_we & ctl_data[1];
  assign sel_d = ctl_we ? ctl_data[7:6] : sel_q;
  assign drop  = rx_push & full & ~clr;

  always_comb begin
    in_ent.brk  = rx_brk;
    in_ent.ferr = rx_ferr | rx_brk;
    in_ent.perr = rx_perr;
    in_ent.data = rx_brk ? 8'h00 : rx_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      sel_q <= 2'b00;
    end else if (ctl_we) begin
      en_q  <= ctl_data[0];
      sel_q <= ctl_data[7:6];
    end
  end

  urxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .wr_en(rx_push), .wr_ent(in_ent), .rd_en(buf_rd),
    .clr(clr), .cap_one(~en_q), .head(head), .full(full), .wr_ok(wr_ok),
    .rd_ok(rd_ok), .cnt_q(cnt_q), .cnt_d(cnt_d)
  );

  urxq_flags #(.CW(CW)) u_flags (
    .clk(clk), .rst(rst), .cnt_d(cnt_d), .sel_d(sel_d), .drop(drop),
    .stat_rd(stat_rd), .drdy_q(data_ready), .trig_q(trig_hit), .ovr_q(overrun)
  );

  urxq_timeout #(.CW(CW), .TO_CHARS(TO_CHARS)) u_to (
    .clk(clk), .rst(rst), .tick(char_tick), .busy(rx_busy), .push(wr_ok),
    .rd_ok(rd_ok), .clr(clr), .cnt_q(cnt_q), .trig_q(trig_hit), .to_q(char_timeout)
  );

  assign buf_data = head.data;
  assign buf_perr = head.perr;
  assign buf_ferr = head.ferr;
  assign buf_brk  = head.brk;

  // R12: data ready tracks the stored occupancy
  p_ready_nonempty_r12: assert property (@(posedge clk) disable iff (rst)
    data_ready == (cnt_q != '0));
  // R8: a stored break carries a zero character with framing error
  p_break_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (data_ready && buf_brk) |-> (buf_data == 8'h00 && buf_ferr));

endmodule

// File: tb/sim_urxq_top.sv
module sim_urxq_top;
  logic clk = 1'b0, rst = 1'b1;
  logic rx_push = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0, rx_busy = 0, char_tick = 0;
  logic ctl_we = 0, buf_rd = 0, stat_rd = 0;
  logic [7:0] rx_data = 0, ctl_data = 0;
  logic [7:0] buf_data;
  logic buf_perr, buf_ferr, buf_brk, data_ready, trig_hit, overrun, char_timeout;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  urxq_top u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic push(input logic [7:0] d, input bit p = 0, input bit f = 0, input bit b = 0);
    rx_push = 1; rx_data = d; rx_perr = p; rx_ferr = f; rx_brk = b;
    cyc();
    rx_push = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
  endtask

  task automatic rd(); buf_rd = 1; cyc(); buf_rd = 0; endtask
  task automatic ctl(input logic [7:0] v); ctl_we = 1; ctl_data = v; cyc(); ctl_we = 0; endtask
  task automatic tick(); char_tick = 1; cyc(); char_tick = 0; endtask
  task automatic srd(); stat_rd = 1; cyc(); stat_rd = 0; endtask

  function automatic int lvl(input int s);
    return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(); cyc(); rst = 0; cyc();
    // R1 reset state
    chk(!data_ready && !trig_hit && !overrun && !char_timeout, "R1 reset flags",
        {data_ready, trig_hit, overrun, char_timeout}, 0);

    // R5 R12 R2 sweep of every trigger level over every occupancy
    for (int s = 0; s < 4; s++) begin
      ctl(8'((s << 6) | 3));
      chk(!data_ready, "R6 clear on level change", data_ready, 0);
      for (int n = 1; n <= 16; n++) begin
        push(8'((n * 29 + s * 3) & 255));
        chk(data_ready, "R12 ready after push", data_ready, 1);
        chk(trig_hit == (n >= lvl(s)), "R5 trigger on fill", trig_hit, n >= lvl(s));
      end
      for (int n = 1; n <= 16; n++) begin
        chk(buf_data == 8'((n * 29 + s * 3) & 255), "R2 order", buf_data, (n * 29 + s * 3) & 255);
        rd();
        chk(trig_hit == ((16 - n) >= lvl(s)), "R5 trigger on drain", trig_hit, (16 - n) >= lvl(s));
        chk(data_ready == (n != 16), "R12 ready on drain", data_ready, n != 16);
      end
      chk(!overrun, "R3 no overrun at depth", overrun, 0);
    end

    // R3 R4 overflow
    ctl(8'h01);
    for (int n = 0; n < 16; n++) push(8'(n + 8'h10));
    chk(!overrun, "R3 full without drop", overrun, 0);
    push(8'hEE);
    chk(overrun, "R3 overrun on drop", overrun, 1);
    cyc(); cyc();
    chk(overrun, "R4 overrun holds", overrun, 1);
    srd();
    chk(!overrun, "R4 overrun cleared", overrun, 0);
    for (int n = 0; n < 16; n++) begin
      chk(buf_data == 8'(n + 8'h10), "R3 stored intact", buf_data, n + 8'h10);
      rd();
    end
    chk(!data_ready, "R3 dropped char absent", data_ready, 0);

    // R7 read while empty
    rd(); rd();
    chk(!data_ready, "R7 empty read", data_ready, 0);
    push(8'h5A);
    chk(data_ready && buf_data == 8'h5A, "R7 one char after empty read", buf_data, 8'h5A);
    rd();
    chk(!data_ready, "R7 single read empties", data_ready, 0);

    // R6 clear versus keep
    push(8'h61); push(8'h62); push(8'h63);
    ctl(8'hC5);
    chk(data_ready && buf_data == 8'h61, "R6 write without clear keeps", buf_data, 8'h61);
    chk(!trig_hit, "R5 level 14 with three", trig_hit, 0);
    ctl(8'h03);
    chk(!data_ready, "R6 clear empties", data_ready, 0);

    // R8 break and flags
    push(8'h41, 0, 0, 1);
    chk(buf_data == 8'h00 && buf_brk && buf_ferr && !buf_perr, "R8 break entry",
        {buf_brk, buf_ferr, buf_perr, buf_data}, 11'h600);
    push(8'h33, 1, 0, 0);
    rd();
    chk(buf_data == 8'h33 && buf_perr && !buf_brk && !buf_ferr, "R2 parity flag",
        {buf_brk, buf_ferr, buf_perr, buf_data}, 11'h133);
    rd();

    // R9 timeout below trigger
    ctl(8'h41);
    push(8'h54);
    repeat (3) tick();
    chk(!char_timeout, "R9 no timeout after three", char_timeout, 0);
    tick();
    chk(char_timeout, "R9 timeout after four", char_timeout, 1);
    rd();
    chk(!char_timeout && !data_ready, "R9 read clears", {char_timeout, data_ready}, 0);

    // R10 restart by line activity and by push
    push(8'h55);
    repeat (3) tick();
    rx_busy = 1; cyc(); rx_busy = 0;
    repeat (3) tick();
    chk(!char_timeout, "R10 busy restarts", char_timeout, 0);
    push(8'h56);
    repeat (3) tick();
    chk(!char_timeout, "R10 push restarts", char_timeout, 0);
    tick();
    chk(char_timeout, "R10 timeout after restart", char_timeout, 1);
    rd(); rd();

    // R9 no timeout at trigger level
    ctl(8'h01);
    push(8'h57);
    chk(trig_hit, "R5 level one reached", trig_hit, 1);
    repeat (5) tick();
    chk(!char_timeout, "R9 no timeout at trigger", char_timeout, 0);
    rd();

    // R11 single character mode
    ctl(8'h02);
    push(8'hA1); push(8'hA2);
    chk(overrun, "R11 second char dropped", overrun, 1);
    chk(buf_data == 8'hA1, "R11 head kept", buf_data, 8'hA1);
    rd();
    chk(!data_ready, "R11 capacity one", data_ready, 0);
    srd();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule